// File: doc/BRIEF.md
# Dead-Time Measurement Scaler Bank

This block measures how much of the run an acquisition system spends unable to accept events. It keeps four saturating event counters. Two of them count triggers: one counts every trigger and the other counts only the triggers that arrive while the busy level is low. The other two count an internal reference pulser, which is the 40 MHz clock divided down to 10 kHz. One of these counts every pulser tick and the other counts only the ticks that occur while busy is low.

The pulser pair is the preferred dead-time estimate. The ratio of its vetoed count to its free count does not depend on how clean the trigger input is, so a trigger that fires twice on one event does not distort it. The raw and live trigger counts are still kept as a cross-check.

A clear strobe zeroes all four counters together. A latch strobe copies all four into holding registers on one clock edge, and the holding registers drive the outputs. The snapshot therefore never mixes values from different cycles. The pulser tick is also brought out so that it can feed other equipment.

Top module: `deadtime_scaler_bank`

## Requirements
- R1: The raw trigger count goes up by one for each rising edge of `trig_in`, however long the level stays high. A rising edge reaches the counter on the second clock edge after `trig_in` goes high.
- R2: The live trigger count goes up only for a rising edge of `trig_in` that is seen while `busy_in` is low. `busy_in` passes through the same one-register delay as `trig_in`, so the two are sampled together.
- R3: `pulser_out` is high for exactly one clock cycle once every `PULSE_DIV` cycles. The default of 4000 gives 10 kHz from a 40 MHz clock.
- R4: The free pulser count goes up by one on every pulser tick, whatever the level of `busy_in`.
- R5: The vetoed pulser count goes up on a pulser tick only while the registered busy level is low.
- R6: Every counter stops at its all-ones value and does not wrap.
- R7: A clock edge with `latch_in` high copies all four counters into the four snapshot outputs together. Without `latch_in`, the snapshot outputs hold their values.
- R8: A clock edge with `clear_in` high zeroes all four counters. If an increment falls on the same edge, the clear takes priority. The clear does not change the snapshot outputs.
- R9: While `rst` is high, all counters, all snapshot outputs and `pulser_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (40 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Raw trigger level |
| busy_in | input | 1 | Acquisition busy level, high while dead |
| clear_in | input | 1 | Zeroes all four counters |
| latch_in | input | 1 | Copies all four counters to the outputs |
| raw_trig_snap | output | CNT_W | Latched count of raw triggers |
| live_trig_snap | output | CNT_W | Latched count of triggers seen while not busy |
| pulse_free_snap | output | CNT_W | Latched count of all pulser ticks |
| pulse_live_snap | output | CNT_W | Latched count of pulser ticks seen while not busy |
| pulser_out | output | 1 | One-cycle reference pulser tick |

## Verification
The assertions assume that `trig_in` and `busy_in` are synchronous to `clk` and that `clear_in` and `latch_in` are clean one-cycle strobes. The properties on step size and ordering also assume that the live count is never cleared apart from the raw count. The bench drives every input on the falling clock edge. It sets `busy_in` a few cycles before each trigger train so that the level is stable when the trigger edges are sampled. It issues each strobe for a single cycle. Pulser windows are timed as exact multiples of the divider length, so the expected tick counts do not depend on the pulser phase.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int NUM_CH   = 4;
  localparam int IDX_RAW  = 0;
  localparam int IDX_LIVE = 1;
  localparam int IDX_PFREE = 2;
  localparam int IDX_PLIVE = 3;
endpackage

// File: rtl/dts_edge_sync.sv
module dts_edge_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] stage_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= din;
      prev_q  <= stage_q;
    end
  end

  assign rise = stage_q & ~prev_q;
endmodule

// File: rtl/dts_pulser.sv
module dts_pulser #(
  parameter int DIV = 4000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (div_q == LAST);
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/dts_sat_counter.sv
module dts_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != TOP)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/deadtime_scaler_bank.sv
module deadtime_scaler_bank
  import dts_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_DIV = 4000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             busy_in,
  input  logic             clear_in,
  input  logic             latch_in,
  output logic [CNT_W-1:0] raw_trig_snap,
  output logic [CNT_W-1:0] live_trig_snap,
  output logic [CNT_W-1:0] pulse_free_snap,
  output logic [CNT_W-1:0] pulse_live_snap,
  output logic             pulser_out
);
  logic                              trig_rise;
  logic                              busy_q;
  logic                              pulse_tick;
  logic [NUM_CH-1:0]                 inc;
  logic [NUM_CH-1:0][CNT_W-1:0]      cnt_q;
  logic [NUM_CH-1:0][CNT_W-1:0]      snap_q;

  dts_edge_sync #(.W(1)) u_trig_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (trig_in),
    .rise (trig_rise)
  );

  // busy goes through one register, the same delay as the trigger stage
  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_in;
  end

  dts_pulser #(.DIV(PULSE_DIV)) u_pulser (
    .clk  (clk),
    .rst  (rst),
    .tick (pulse_tick)
  );

  always_comb begin
    inc            = '0;
    inc[IDX_RAW]   = trig_rise;
    inc[IDX_LIVE]  = trig_rise & ~busy_q;
    inc[IDX_PFREE] = pulse_tick;
    inc[IDX_PLIVE] = pulse_tick & ~busy_q;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cnt
    dts_sat_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clear_in),
      .inc (inc[ch]),
      .cnt (cnt_q[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)           snap_q <= '0;
    else if (latch_in) snap_q <= cnt_q;
  end

  assign raw_trig_snap   = snap_q[IDX_RAW];
  assign live_trig_snap  = snap_q[IDX_LIVE];
  assign pulse_free_snap = snap_q[IDX_PFREE];
  assign pulse_live_snap = snap_q[IDX_PLIVE];
  assign pulser_out      = pulse_tick;
endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clear_in,
  input logic                  latch_in,
  input logic                  pulser_out,
  input logic [3:0][CNT_W-1:0] cnt,
  input logic [3:0][CNT_W-1:0] snap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_RAW_STEP: assert property (@(posedge clk) disable iff (rst)
    !clear_in |=> (cnt[0] == $past(cnt[0])) || (cnt[0] == $past(cnt[0]) + 1'b1)); // R1
  AST_LIVE_LE_RAW: assert property (@(posedge clk) disable iff (rst)
    cnt[1] <= cnt[0]); // R2
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pulser_out |=> !pulser_out); // R3
  AST_PLIVE_LE_PFREE: assert property (@(posedge clk) disable iff (rst)
    cnt[3] <= cnt[2]); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt[0] == TOP) && !clear_in |=> cnt[0] == TOP); // R6
  AST_NO_OVERFLOW_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cnt[2] == TOP) && !clear_in |=> cnt[2] == TOP); // R6
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
    latch_in |=> snap == $past(cnt)); // R7
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !latch_in |=> $stable(snap)); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clear_in |=> cnt == '0); // R8
endmodule

bind deadtime_scaler_bank dts_checker #(.CNT_W(CNT_W)) u_dts_checker (
  .clk        (clk),
  .rst        (rst),
  .clear_in   (clear_in),
  .latch_in   (latch_in),
  .pulser_out (pulser_out),
  .cnt        (cnt_q),
  .snap       (snap_q)
);

// File: tb/test_deadtime_scaler_bank.sv
module test_deadtime_scaler_bank;
  localparam int CLK_PERIOD = 25;
  localparam int CW   = 4;
  localparam int PDIV = 20;
  localparam int MAXV = (1 << CW) - 1;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic       busy;
    logic [7:0] n;
    logic [3:0] w;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{busy: 1'b0, n: 8'd3,  w: 4'd1},
    '{busy: 1'b1, n: 8'd4,  w: 4'd1},
    '{busy: 1'b0, n: 8'd2,  w: 4'd6},
    '{busy: 1'b0, n: 8'd20, w: 4'd1},
    '{busy: 1'b1, n: 8'd17, w: 4'd2},
    '{busy: 1'b0, n: 8'd0,  w: 4'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0, busy_in = 1'b0, clear_in = 1'b0, latch_in = 1'b0;
  logic [CW-1:0] raw_s, live_s, pfree_s, plive_s;
  logic pulser_out;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deadtime_scaler_bank #(.CNT_W(CW), .PULSE_DIV(PDIV)) i_deadtime_scaler_bank (
    .clk             (clk),
    .rst             (rst),
    .trig_in         (trig_in),
    .busy_in         (busy_in),
    .clear_in        (clear_in),
    .latch_in        (latch_in),
    .raw_trig_snap   (raw_s),
    .live_trig_snap  (live_s),
    .pulse_free_snap (pfree_s),
    .pulse_live_snap (plive_s),
    .pulser_out      (pulser_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  // called at a falling edge; returns at a falling edge
  task automatic do_clear();
    clear_in = 1'b1;
    @(negedge clk);
    clear_in = 1'b0;
  endtask

  task automatic do_latch();
    latch_in = 1'b1;
    @(negedge clk);
    latch_in = 1'b0;
  endtask

  task automatic pulse_train(input logic b, input int n, input int w);
    busy_in = b;
    repeat (3) @(negedge clk);
    for (int p = 0; p < n; p++) begin
      trig_in = 1'b1;
      repeat (w) @(negedge clk);
      trig_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int gap;
    int hold_raw;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 raw snap in reset", raw_s, 0);
    chk("R9 live snap in reset", live_s, 0);
    chk("R9 pulser snaps in reset", pfree_s + plive_s, 0);
    chk("R9 pulser_out in reset", pulser_out, 0);
    rst = 1'b0;
    @(negedge clk);
    do_latch();
    chk("R9 raw snap after reset", raw_s, 0);

    // vector table: R1 R2 R6
    foreach (VECS[i]) begin
      int er, el;
      er = (int'(VECS[i].n) > MAXV) ? MAXV : int'(VECS[i].n);
      el = VECS[i].busy ? 0 : er;
      do_clear();
      pulse_train(VECS[i].busy, int'(VECS[i].n), int'(VECS[i].w));
      do_latch();
      chk($sformatf("R1/R6 raw vec %0d", i), raw_s, er);
      chk($sformatf("R2/R6 live vec %0d", i), live_s, el);
    end

    // R2: busy changes between triggers
    do_clear();
    pulse_train(1'b0, 1, 1);
    pulse_train(1'b1, 2, 1);
    pulse_train(1'b0, 1, 3);
    do_latch();
    chk("R2 raw mixed busy", raw_s, 4);
    chk("R2 live mixed busy", live_s, 2);

    // R7: snapshot holds without latch
    hold_raw = raw_s;
    pulse_train(1'b0, 3, 1);
    chk("R7 snapshot holds raw", raw_s, hold_raw);
    chk("R7 snapshot holds live", live_s, 2);

    // R8: clear on the same edge as an increment; snapshot untouched
    busy_in = 1'b0;
    @(negedge clk);
    trig_in = 1'b1;
    @(negedge clk);
    do_clear();
    chk("R8 clear leaves snapshot", raw_s, hold_raw);
    repeat (2) @(negedge clk);
    trig_in = 1'b0;
    repeat (2) @(negedge clk);
    do_latch();
    chk("R8 clear wins raw", raw_s, 0);
    chk("R8 clear wins live", live_s, 0);

    // R3: pulser period and width
    while (pulser_out !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk("R3 pulse width", pulser_out, 0);
    gap = 1;
    while (pulser_out !== 1'b1 && gap < 4 * PDIV) begin
      @(negedge clk);
      gap++;
    end
    chk("R3 pulse period", gap, PDIV);

    // R4 R5: pulser counts with busy high, then low
    busy_in = 1'b1;
    repeat (3) @(negedge clk);
    do_clear();
    repeat (3 * PDIV) @(negedge clk);
    do_latch();
    chk("R4 free pulser busy", pfree_s, 3);
    chk("R5 vetoed pulser busy", plive_s, 0);
    busy_in = 1'b0;
    repeat (3) @(negedge clk);
    do_clear();
    repeat (3 * PDIV) @(negedge clk);
    do_latch();
    chk("R4 free pulser idle", pfree_s, 3);
    chk("R5 vetoed pulser idle", plive_s, 3);

    // R6: pulser counters saturate
    repeat (20 * PDIV) @(negedge clk);
    do_latch();
    chk("R6 free pulser saturates", pfree_s, MAXV);
    chk("R6 vetoed pulser saturates", plive_s, MAXV);

    finish_run();
  end
endmodule